// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous memory with a registered read pipeline and a late-write protocol. Every command is taken on a rising clock edge. The command consists of a chip select, a write strobe, per-lane write enables and an address. A read returns its word through an output register one edge later. A write takes its address on one edge and its data on the following edge. The host can therefore present a new address in the same cycle that it drives the data of the previous write.

Write data is not stored in the array at once. It is parked in a one-entry write buffer together with its address and lane mask. The entry is committed to the array only when the next real write takes the buffer's place. An address comparator watches every read. When a read hits the buffered address, the lanes that the buffer holds are substituted into the word read from the array. Reads therefore always see the newest data, and the buffer is invisible to the host. The word is divided into 9-bit lanes, and each lane has its own active-low write enable.

Top module: `lw_sram`

## Requirements
- R1: After reset, `rvalid` is 0, `rdata` is all zeros and the write buffer is empty.
- R2: A read is `sel_n`=0 with `wr_n`=1 at a rising edge. The addressed word appears on `rdata` after the next rising edge, and `rvalid` is high for exactly that one cycle.
- R3: A write is `sel_n`=0 with `wr_n`=0 at a rising edge. It takes its address and lane enables on that edge and takes `wdata` on the following edge.
- R4: A read of the address held in the write buffer returns the buffered bytes for the lanes in the buffered mask. It returns the array contents for all other lanes.
- R5: When a new write with at least one enabled lane has its data sampled, the previously buffered entry is first merged into the array under its own lane mask. A read issued in the cycle after a write's address cycle already returns that write's data.
- R6: Lane i occupies bits [9i+8:9i] of `wdata` and `rdata`. It is written only if `lane_we_n[i]` is 0 during the write's address cycle.
- R7: The value of `lane_we_n` during a read has no effect on the returned word.
- R8: A write with every `lane_we_n` bit set to 1 changes no memory contents and does not raise `rvalid`.
- R9: A write cycle never raises `rvalid`. `rdata` keeps its last read value whenever `rvalid` is low.
- R10: With `sel_n`=1, the values of `wr_n`, `lane_we_n`, `addr` and `wdata` have no effect on memory contents or outputs.
- R11: Reads may be issued on consecutive cycles, and each returns its own word one cycle after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (1 = read) |
| lane_we_n | input | LANES | Active-low write enable for each 9-bit lane |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled one edge after the write address |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | High for the cycle in which `rdata` holds a new read result |

## Verification
The memory is first filled with full-word writes issued back to back, so every entry except the last passes through the commit path. It is then read back with random lane enables on the read cycles. A sweep then goes over every address and every lane mask, including the all-disabled mask. Each write is followed at once by a read of the same address, which can only be served by bypass. A read of a neighbouring address, an unrelated commit-forcing write and a second read follow, so errors in the mask merge, the comparator and the array commit each show up at a different point. Two writes to one address on consecutive cycles with disjoint lanes, and a run of deselected cycles carrying write-like noise, separate buffer-overwrite and select-gating faults.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Decoded command held in the capture stage
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [ADDR_W-1:0] addr,
  output lw_op_e            stg_op,
  output logic [ADDR_W-1:0] stg_addr,
  output logic [LANES-1:0]  stg_mask
);

  lw_op_e nxt_op;

  always_comb begin
    if (sel_n)     nxt_op = OP_NONE;
    else if (wr_n) nxt_op = OP_READ;
    else           nxt_op = OP_WRITE;
  end

  // Capture stage: address and controls registered on every edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_op   <= OP_NONE;
      stg_addr <= '0;
      stg_mask <= '0;
    end else begin
      stg_op   <= nxt_op;
      stg_addr <= addr;
      // lane enables only matter for writes (R7)
      stg_mask <= (nxt_op == OP_WRITE) ? ~lane_we_n : '0;
    end
  end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [LANES-1:0]        ld_mask,
  input  logic [LANES*LANE_W-1:0] ld_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    buf_valid,
  output logic [ADDR_W-1:0]       buf_addr,
  output logic [LANES-1:0]        buf_mask,
  output logic [LANES*LANE_W-1:0] buf_data,
  output logic                    commit_en,
  output logic                    hit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_mask  <= '0;
      buf_data  <= '0;
    end else if (load_en) begin
      buf_valid <= 1'b1;
      buf_addr  <= ld_addr;
      buf_mask  <= ld_mask;
      buf_data  <= ld_data;
    end
  end

  // The old entry drains into the array on the same edge the new one lands
  assign commit_en = load_en && buf_valid;
  assign hit       = buf_valid && (buf_addr == rd_addr);

  // R8: without a load, the parked entry does not move
  p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(buf_valid) && $stable(buf_addr) && $stable(buf_data)));

  // R5: once filled, the buffer is only replaced, never emptied
  p_buf_stays_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |=> buf_valid);

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Lane-wise merge: lanes set in msk take nw, the rest keep old
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old,
    input logic [DATA_W-1:0] nw,
    input logic [LANES-1:0]  msk
  );
    logic [DATA_W-1:0] res;
    res = old;
    for (int i = 0; i < LANES; i++)
      if (msk[i]) res[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= lane_merge(mem[waddr], wdata, wmask);
  end

  assign rdata = mem[raddr];

  // R5: a commit always carries at least one lane
  p_commit_has_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wmask != '0));

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  lw_op_e            stg_op;
  logic [ADDR_W-1:0] stg_addr;
  logic [LANES-1:0]  stg_mask;

  lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .lane_we_n(lane_we_n),
    .addr     (addr),
    .stg_op   (stg_op),
    .stg_addr (stg_addr),
    .stg_mask (stg_mask)
  );

  // Named internal events
  logic              do_read;
  logic              load_en;
  logic              commit_en;
  logic              bypass_hit;
  logic              buf_valid;
  logic [ADDR_W-1:0] buf_addr;
  logic [LANES-1:0]  buf_mask;
  logic [DATA_W-1:0] buf_data;
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] merged;

  assign do_read = (stg_op == OP_READ);
  // A write with no lane enabled is neither read nor write (R8)
  assign load_en = (stg_op == OP_WRITE) && (stg_mask != '0);

  lw_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .ld_addr  (stg_addr),
    .ld_mask  (stg_mask),
    .ld_data  (wdata),
    .rd_addr  (stg_addr),
    .buf_valid(buf_valid),
    .buf_addr (buf_addr),
    .buf_mask (buf_mask),
    .buf_data (buf_data),
    .commit_en(commit_en),
    .hit      (bypass_hit)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (commit_en),
    .waddr(buf_addr),
    .wmask(buf_mask),
    .wdata(buf_data),
    .raddr(stg_addr),
    .rdata(arr_q)
  );

  // Bypass mux, one per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (bypass_hit && buf_mask[g])
                                      ? buf_data[g*LANE_W +: LANE_W]
                                      : arr_q[g*LANE_W +: LANE_W];
  end

  // Output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= do_read;
      if (do_read) rdata <= merged;
    end
  end

  // R2: a read command yields rvalid two edges later
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && wr_n) |=> ##1 rvalid);

  // R9: a write command never produces read data
  p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n) |=> ##1 !rvalid);

  // R9: output data holds between reads
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> $stable(rdata));

  // R10: deselected cycles produce nothing
  p_desel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> ##1 !rvalid);

  // R4: a hit on a full-word buffer entry returns the buffer word
  p_full_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_read && bypass_hit && (buf_mask == '1)) |=> (rdata == $past(buf_data)));

endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;

  localparam int AW = 3;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int NW = 1 << AW;

  localparam int K_IDLE = 0;
  localparam int K_RD   = 1;
  localparam int K_WR   = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n;
  logic          wr_n;
  logic [LN-1:0] lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2 clk = ~clk;

  lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
    .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  logic [DW-1:0] model [NW];
  logic          e_v  [2];
  logic          e_rd [2];
  logic [DW-1:0] e_d  [2];
  string         e_t  [2];
  logic          pw_v;
  logic [AW-1:0] pw_a;
  logic [LN-1:0] pw_m;
  logic [DW-1:0] pw_d;
  logic [DW-1:0] last_rd;

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 437) ^ (i << 9) ^ 32'h2A5A5);
  endfunction

  // Expected lane merge written as a mask expansion
  function automatic logic [DW-1:0] apply_lanes(input logic [DW-1:0] old,
      input logic [DW-1:0] nw, input logic [LN-1:0] m);
    logic [DW-1:0] wide;
    wide = '0;
    for (int i = 0; i < LN; i++) if (m[i]) wide |= {{(DW-LW){1'b0}}, {LW{1'b1}}} << (i * LW);
    return (old & ~wide) | (nw & wide);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp, input logic av, input logic ev);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: rdata=%h rvalid=%b expected rdata=%h rvalid=%b", tag, act, av, exp, ev);
    end
  endtask

  task automatic op(input int kind, input logic [AW-1:0] a, input logic [LN-1:0] wen_n,
                    input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    if (e_v[1]) begin
      if (e_rd[1]) begin
        chk(rvalid === 1'b1 && rdata === e_d[1], e_t[1], rdata, e_d[1], rvalid, 1'b1);
        last_rd = e_d[1];
      end else begin
        chk(rvalid === 1'b0 && rdata === last_rd, e_t[1], rdata, last_rd, rvalid, 1'b0);
      end
    end
    e_v[1] = e_v[0]; e_rd[1] = e_rd[0]; e_d[1] = e_d[0]; e_t[1] = e_t[0];
    if (pw_v) model[pw_a] = apply_lanes(model[pw_a], pw_d, pw_m);
    wdata = pw_v ? pw_d : DW'($urandom);
    pw_v  = 1'b0;
    addr  = a;
    e_v[0] = 1'b1; e_rd[0] = 1'b0; e_d[0] = '0; e_t[0] = tag;
    case (kind)
      K_RD: begin
        sel_n = 1'b0; wr_n = 1'b1; lane_we_n = wen_n;
        e_rd[0] = 1'b1; e_d[0] = model[a];
      end
      K_WR: begin
        sel_n = 1'b0; wr_n = 1'b0; lane_we_n = wen_n;
        pw_v = 1'b1; pw_a = a; pw_m = ~wen_n; pw_d = d;
      end
      default: begin
        sel_n = 1'b1; wr_n = 1'($urandom); lane_we_n = LN'($urandom);
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    e_v[0] = 0; e_v[1] = 0; e_rd[0] = 0; e_rd[1] = 0;
    e_d[0] = '0; e_d[1] = '0; e_t[0] = ""; e_t[1] = "";
    pw_v = 0; pw_a = '0; pw_m = '0; pw_d = '0;
    rst_n = 0; sel_n = 1; wr_n = 1; lane_we_n = '1; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state
    @(negedge clk);
    chk(rvalid === 1'b0 && rdata === '0, "R1", rdata, '0, rvalid, 1'b0);
    last_rd = '0;

    // R3/R5: full-word fill, back to back
    for (int a = 0; a < NW; a++) op(K_WR, AW'(a), '0, pat(a), "R3");
    // R11/R7: consecutive reads with arbitrary lane enables
    for (int a = 0; a < NW; a++) op(K_RD, AW'(a), LN'($urandom), '0, "R11");

    // R4/R6/R8: every address, every lane mask
    for (int a = 0; a < NW; a++) begin
      for (int m = 0; m < (1 << LN); m++) begin
        op(K_WR, AW'(a), LN'(m), pat(a * 8 + m + 100), (m == (1 << LN) - 1) ? "R8" : "R6");
        op(K_RD, AW'(a), LN'($urandom), '0, "R4");
        op(K_RD, AW'(a + 1), LN'($urandom), '0, "R2");
        op(K_WR, AW'(a + 3), '0, pat(a * 8 + m + 500), "R9");
        op(K_RD, AW'(a), '1, '0, "R5");
      end
    end

    // R5: two writes to one address with disjoint lanes, then read
    for (int a = 0; a < NW; a++) begin
      op(K_WR, AW'(a), 2'b10, pat(a + 900), "R6");
      op(K_WR, AW'(a), 2'b01, pat(a + 950), "R5");
      op(K_RD, AW'(a), '0, '0, "R5");
      op(K_IDLE, '0, '0, '0, "R10");
      op(K_RD, AW'(a), '0, '0, "R5");
    end

    // R10: deselected noise, then read everything back
    for (int i = 0; i < 12; i++) op(K_IDLE, AW'($urandom), '0, '0, "R10");
    for (int a = 0; a < NW; a++) op(K_RD, AW'(a), '0, '0, "R10");
    op(K_IDLE, '0, '0, '0, "R10");
    op(K_IDLE, '0, '0, '0, "R10");
    op(K_IDLE, '0, '0, '0, "R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule